// File: doc/BRIEF.md
# Pending interrupt acknowledge arbiter

The block keeps a small file of list entries for one virtual CPU interface. Each entry names a virtual interrupt ID, an 8-bit priority, a group bit, a pending bit, an active bit, a hardware-linked flag and a physical ID. A write port loads any entry, and a combinational read port shows any entry. Software or a loader fills the file. Only the first `used_cnt_i` entries take part in arbitration.

When an acknowledge request arrives for group 0 or group 1, a combinational tournament tree picks the best pending entry. The winner must then pass three checks. Its group must match the request, its priority must sit below the priority mask, and its preemption level must sit below the running priority. The preemption level is the priority with its subpriority bits cleared by the group's binary point. If all checks pass, the entry moves from pending to active, and the block returns the entry's ID together with the preemption level for an active-priority tracker. If any check fails, the block returns the spurious ID 1023. A separate query port reports the highest pending ID for a group. The query changes no state.

Top module: `pend_ack_arb`

## Requirements
- R1: While reset is asserted and after it, `ack_done_o` and `ack_ok_o` are 0, and every entry reads back with all fields 0.
- R2: An entry is a candidate only if its index is below `used_cnt_i` and its state is exactly pending (pending=1, active=0). Entries that are pending and active, or active only, are never selected.
- R3: A group-0 entry is a candidate only while `grp0_en_i`=1. A group-1 entry is a candidate only while `grp1_en_i`=1.
- R4: Among candidates, the numerically lowest priority wins, and on a tie the lower index wins. An entry with priority 0xFF is never selected.
- R5: If there is no winner, or the winner's group differs from `ack_grp_i`, the result carries `ack_ok_o`=0 and `ack_vid_o`=1023.
- R6: If `prio_mask_i` is less than or equal to the winner's priority, the result is spurious (1023, not ok).
- R7: The preemption level is the priority ANDed with 0xFF shifted left by `bpr0_i`+1 for group 0, or by `bpr1_i` for group 1. If `run_prio_i` is less than or equal to this level, the result is spurious.
- R8: On success, one cycle after the request, `ack_ok_o`=1, `ack_vid_o` is the entry's ID and `ack_pre_o` is its preemption level. In the same cycle the entry reads pending=0 and active=1, with ID, priority, group, hardware flag and physical ID unchanged.
- R9: `hp_vid_o` gives, combinationally, the ID of the winner for `hp_grp_i`. It gives 1023 when there is no winner or the groups differ. It ignores the mask and the running priority, and it changes no entry.
- R10: `ack_done_o` is high for exactly the one cycle after each request cycle. A spurious acknowledge leaves every entry unchanged.
- R11: When `wr_en_i`=1, all fields of entry `wr_idx_i` take the write values at the clock edge. The read port shows entry `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | 4 | Entry index to write |
| wr_vid_i | input | 10 | Virtual ID to write |
| wr_prio_i | input | 8 | Priority to write |
| wr_grp_i | input | 1 | Group to write |
| wr_pend_i | input | 1 | Pending bit to write |
| wr_act_i | input | 1 | Active bit to write |
| wr_hw_i | input | 1 | Hardware-linked flag to write |
| wr_pid_i | input | 10 | Physical ID to write |
| rd_idx_i | input | 4 | Entry index to read |
| rd_vid_o | output | 10 | Read entry virtual ID |
| rd_prio_o | output | 8 | Read entry priority |
| rd_grp_o | output | 1 | Read entry group |
| rd_pend_o | output | 1 | Read entry pending bit |
| rd_act_o | output | 1 | Read entry active bit |
| rd_hw_o | output | 1 | Read entry hardware-linked flag |
| rd_pid_o | output | 10 | Read entry physical ID |
| used_cnt_i | input | 5 | Number of entries in use, 0 to 16 |
| grp0_en_i | input | 1 | Group-0 enable |
| grp1_en_i | input | 1 | Group-1 enable |
| prio_mask_i | input | 8 | Priority mask |
| run_prio_i | input | 8 | Current running priority |
| bpr0_i | input | 3 | Group-0 binary point |
| bpr1_i | input | 3 | Group-1 binary point |
| ack_req_i | input | 1 | Acknowledge request |
| ack_grp_i | input | 1 | Group of the acknowledge request |
| ack_done_o | output | 1 | Acknowledge result valid |
| ack_ok_o | output | 1 | Acknowledge succeeded |
| ack_vid_o | output | 10 | Acknowledged ID or 1023 |
| ack_pre_o | output | 8 | Preemption level of the acknowledged entry |
| hp_grp_i | input | 1 | Group for the highest-pending query |
| hp_vid_o | output | 10 | Highest pending ID or 1023 |

## Verification
The query result and the read port are combinational, so the bench samples them a short delay after it changes their inputs, within the same cycle. The acknowledge result, the done strobe and the pending-to-active update of the entry all take effect at the clock edge that follows the request cycle. The bench raises the request on one falling edge and checks the result on the next falling edge, and it checks one cycle later that the strobe has dropped. Entry writes take effect at the next clock edge, so each readback is taken after that edge.

// File: rtl/pend_ack_pkg.sv
package pend_ack_pkg;
  localparam int VID_W  = 10;
  localparam int PRIO_W = 8;
  localparam logic [VID_W-1:0]  SPUR_VID  = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [PRIO_W-1:0] prio;
    logic              grp;
    logic              pend;
    logic              act;
    logic              hw;
    logic [VID_W-1:0]  pid;
  } lr_ent_t;
endpackage

// File: rtl/pend_ack_file.sv
module pend_ack_file
  import pend_ack_pkg::*;
#(
  parameter int NUM_LR = 16,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  lr_ent_t          wr_ent_i,
  input  logic             com_en_i,
  input  logic [IDX_W-1:0] com_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output lr_ent_t          rd_ent_o,
  output lr_ent_t          ents_o [NUM_LR]
);
  lr_ent_t ent_q [NUM_LR];

  for (genvar k = 0; k < NUM_LR; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[k] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(k)) begin
        ent_q[k] <= wr_ent_i;  // write wins over commit
      end else if (com_en_i && com_idx_i == IDX_W'(k)) begin
        ent_q[k].pend <= 1'b0;
        ent_q[k].act  <= 1'b1;
      end
    end
    assign ents_o[k] = ent_q[k];
  end

  assign rd_ent_o = ent_q[rd_idx_i];
endmodule

// File: rtl/pend_ack_pick.sv
module pend_ack_pick
  import pend_ack_pkg::*;
#(
  parameter int NUM_LR = 16,  // power of two
  localparam int IDX_W = $clog2(NUM_LR),
  localparam int CNT_W = $clog2(NUM_LR + 1),
  localparam int NODES = 2 * NUM_LR - 1
) (
  input  lr_ent_t          ents_i [NUM_LR],
  input  logic [CNT_W-1:0] used_cnt_i,
  input  logic             grp0_en_i,
  input  logic             grp1_en_i,
  output logic             win_v_o,
  output logic [IDX_W-1:0] win_idx_o
);
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar k = 0; k < NUM_LR; k++) begin : g_leaf
    assign nv[NUM_LR-1+k] = (CNT_W'(k) < used_cnt_i) && ents_i[k].pend && !ents_i[k].act &&
                            (ents_i[k].grp ? grp1_en_i : grp0_en_i) &&
                            (ents_i[k].prio != IDLE_PRIO);
    assign np[NUM_LR-1+k] = ents_i[k].prio;
    assign ni[NUM_LR-1+k] = IDX_W'(k);
  end

  // left subtree holds lower indices; left kept on tie
  for (genvar n = 0; n < NUM_LR - 1; n++) begin : g_node
    logic take_l;
    assign take_l = nv[2*n+1] && (!nv[2*n+2] || np[2*n+1] <= np[2*n+2]);
    assign nv[n]  = nv[2*n+1] || nv[2*n+2];
    assign np[n]  = take_l ? np[2*n+1] : np[2*n+2];
    assign ni[n]  = take_l ? ni[2*n+1] : ni[2*n+2];
  end

  assign win_v_o   = nv[0];
  assign win_idx_o = ni[0];
endmodule

// File: rtl/pend_ack_gate.sv
module pend_ack_gate
  import pend_ack_pkg::*;
(
  input  logic              win_v_i,
  input  logic              win_grp_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic              req_grp_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic [2:0]        bpr0_i,
  input  logic [2:0]        bpr1_i,
  output logic              ok_o,
  output logic [PRIO_W-1:0] pre_o
);
  logic [3:0] shamt;

  assign shamt = req_grp_i ? {1'b0, bpr1_i} : ({1'b0, bpr0_i} + 4'd1);
  assign pre_o = win_prio_i & (IDLE_PRIO << shamt);
  assign ok_o  = win_v_i && (win_grp_i == req_grp_i) &&
                 (prio_mask_i > win_prio_i) && (run_prio_i > pre_o);
endmodule

// File: rtl/pend_ack_arb.sv
module pend_ack_arb
  import pend_ack_pkg::*;
#(
  parameter int NUM_LR = 16,
  localparam int IDX_W = $clog2(NUM_LR),
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VID_W-1:0]  wr_vid_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic              wr_grp_i,
  input  logic              wr_pend_i,
  input  logic              wr_act_i,
  input  logic              wr_hw_i,
  input  logic [VID_W-1:0]  wr_pid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [VID_W-1:0]  rd_vid_o,
  output logic [PRIO_W-1:0] rd_prio_o,
  output logic              rd_grp_o,
  output logic              rd_pend_o,
  output logic              rd_act_o,
  output logic              rd_hw_o,
  output logic [VID_W-1:0]  rd_pid_o,
  input  logic [CNT_W-1:0]  used_cnt_i,
  input  logic              grp0_en_i,
  input  logic              grp1_en_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic [2:0]        bpr0_i,
  input  logic [2:0]        bpr1_i,
  input  logic              ack_req_i,
  input  logic              ack_grp_i,
  output logic              ack_done_o,
  output logic              ack_ok_o,
  output logic [VID_W-1:0]  ack_vid_o,
  output logic [PRIO_W-1:0] ack_pre_o,
  input  logic              hp_grp_i,
  output logic [VID_W-1:0]  hp_vid_o
);
  lr_ent_t          wr_ent, rd_ent, win_ent;
  lr_ent_t          ents [NUM_LR];
  logic             win_v, ok, com_en;
  logic [IDX_W-1:0] win_idx;
  logic [PRIO_W-1:0] pre;

  assign wr_ent = '{vid: wr_vid_i, prio: wr_prio_i, grp: wr_grp_i, pend: wr_pend_i,
                    act: wr_act_i, hw: wr_hw_i, pid: wr_pid_i};

  pend_ack_file #(.NUM_LR(NUM_LR)) i_file (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_ent_i(wr_ent),
    .com_en_i(com_en), .com_idx_i(win_idx), .rd_idx_i,
    .rd_ent_o(rd_ent), .ents_o(ents)
  );

  pend_ack_pick #(.NUM_LR(NUM_LR)) i_pick (
    .ents_i(ents), .used_cnt_i, .grp0_en_i, .grp1_en_i,
    .win_v_o(win_v), .win_idx_o(win_idx)
  );

  assign win_ent = ents[win_idx];

  pend_ack_gate i_gate (
    .win_v_i(win_v), .win_grp_i(win_ent.grp), .win_prio_i(win_ent.prio),
    .req_grp_i(ack_grp_i), .prio_mask_i, .run_prio_i, .bpr0_i, .bpr1_i,
    .ok_o(ok), .pre_o(pre)
  );

  assign com_en = ack_req_i && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_done_o <= 1'b0;
      ack_ok_o   <= 1'b0;
      ack_vid_o  <= SPUR_VID;
      ack_pre_o  <= '0;
    end else begin
      ack_done_o <= ack_req_i;
      if (ack_req_i) begin
        ack_ok_o  <= ok;
        ack_vid_o <= ok ? win_ent.vid : SPUR_VID;
        ack_pre_o <= ok ? pre : '0;
      end else begin
        ack_ok_o  <= 1'b0;
      end
    end
  end

  assign hp_vid_o  = (win_v && win_ent.grp == hp_grp_i) ? win_ent.vid : SPUR_VID;

  assign rd_vid_o  = rd_ent.vid;
  assign rd_prio_o = rd_ent.prio;
  assign rd_grp_o  = rd_ent.grp;
  assign rd_pend_o = rd_ent.pend;
  assign rd_act_o  = rd_ent.act;
  assign rd_hw_o   = rd_ent.hw;
  assign rd_pid_o  = rd_ent.pid;
endmodule

// File: rtl/pend_ack_chk.sv
module pend_ack_chk
  import pend_ack_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_req_i,
  input logic              ack_done_o,
  input logic              ack_ok_o,
  input logic [VID_W-1:0]  ack_vid_o,
  input logic [PRIO_W-1:0] ack_pre_o,
  input logic [PRIO_W-1:0] prio_mask_i,
  input logic [PRIO_W-1:0] run_prio_i
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_i |=> ack_done_o);  // R10
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_o |-> $past(ack_req_i));  // R10
  AST_SPUR_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_done_o && !ack_ok_o) |-> ack_vid_o == SPUR_VID);  // R5
  AST_OK_BELOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_o |-> ack_pre_o < $past(prio_mask_i));  // R6
  AST_OK_BELOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_o |-> ack_pre_o < $past(run_prio_i));  // R7
  AST_OK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_o |-> ack_done_o);  // R8
endmodule

bind pend_ack_arb pend_ack_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_req_i(ack_req_i), .ack_done_o(ack_done_o),
  .ack_ok_o(ack_ok_o), .ack_vid_o(ack_vid_o), .ack_pre_o(ack_pre_o),
  .prio_mask_i(prio_mask_i), .run_prio_i(run_prio_i)
);

// File: tb/test_pend_ack_arb.sv
`timescale 1ns/1ps
module test_pend_ack_arb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 0, wr_grp_i = 0, wr_pend_i = 0, wr_act_i = 0, wr_hw_i = 0;
  logic [3:0] wr_idx_i = 0, rd_idx_i = 0;
  logic [9:0] wr_vid_i = 0, wr_pid_i = 0;
  logic [7:0] wr_prio_i = 0;
  logic [9:0] rd_vid_o, rd_pid_o, ack_vid_o, hp_vid_o;
  logic [7:0] rd_prio_o, ack_pre_o;
  logic       rd_grp_o, rd_pend_o, rd_act_o, rd_hw_o, ack_done_o, ack_ok_o;
  logic [4:0] used_cnt_i = 0;
  logic       grp0_en_i = 0, grp1_en_i = 0, ack_req_i = 0, ack_grp_i = 0, hp_grp_i = 0;
  logic [7:0] prio_mask_i = 8'hFF, run_prio_i = 8'hFF;
  logic [2:0] bpr0_i = 0, bpr1_i = 0;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  pend_ack_arb i_pend_ack_arb (.*);

  typedef struct packed {
    logic grp, en0, en1; logic [7:0] mask, run; logic [2:0] b0, b1; logic [4:0] used;
    logic [3:0] idx; logic [9:0] hp; logic ok; logic [9:0] vid; logic [7:0] pre;
  } tv_t;

  // R2 R3 R4 R5 R6 R7 R8 R9 across rows
  localparam tv_t TV [14] = '{
    '{1,1,1,8'hFF,8'hFF,0,0,16,9,49,1,49,8'h08},
    '{1,1,1,8'hFF,8'hFF,0,0, 9,5,1023,0,1023,0},
    '{0,1,1,8'hFF,8'hFF,0,0, 9,5,45,1,45,8'h30},
    '{1,0,1,8'hFF,8'hFF,0,0, 9,1,41,1,41,8'h40},
    '{0,1,0,8'hFF,8'hFF,0,0,16,5,45,1,45,8'h30},
    '{1,1,1,8'h08,8'hFF,0,0,16,9,49,0,1023,0},
    '{1,1,1,8'h09,8'hFF,0,0,16,9,49,1,49,8'h08},
    '{1,1,1,8'hFF,8'h08,0,0,16,9,49,0,1023,0},
    '{1,1,1,8'hFF,8'h08,0,4,16,9,49,1,49,8'h00},
    '{0,1,0,8'hFF,8'h21,4,0, 9,5,45,1,45,8'h20},
    '{0,1,0,8'hFF,8'h20,4,0, 9,5,45,0,1023,0},
    '{1,1,1,8'hFF,8'hFF,0,0, 0,9,1023,0,1023,0},
    '{1,0,0,8'hFF,8'hFF,0,0,16,9,1023,0,1023,0},
    '{0,1,1,8'hFF,8'hFF,0,0, 1,0,40,1,40,8'h60}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entry set: {prio, grp, pend, act}
  task automatic load_set();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      wr_en_i = 1; wr_idx_i = 4'(k); wr_vid_i = 10'(40 + k);
      wr_hw_i = (k == 1); wr_pid_i = (k == 1) ? 10'd300 : 10'd0;
      {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h00, 1'b0, 1'b0, 1'b0};
      case (k)
        0: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h60, 3'b010};
        1: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h40, 3'b110};
        2: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h20, 3'b111};
        3: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h10, 3'b101};
        4: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h40, 3'b110};
        5: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h30, 3'b010};
        6: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'hFF, 3'b110};
        9: {wr_prio_i, wr_grp_i, wr_pend_i, wr_act_i} = {8'h08, 3'b110};
        default: ;
      endcase
    end
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic do_ack(input logic grp);
    @(negedge clk_i);
    ack_req_i = 1; ack_grp_i = grp;
    @(negedge clk_i);
    ack_req_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", ack_done_o, 0);
    chk("R1 ok in reset", ack_ok_o, 0);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 entry0 pend", rd_pend_o, 0);
    chk("R1 entry0 vid", rd_vid_o, 0);
    chk("R1 done after reset", ack_done_o, 0);

    foreach (TV[v]) begin
      load_set();
      grp0_en_i = TV[v].en0; grp1_en_i = TV[v].en1; prio_mask_i = TV[v].mask;
      run_prio_i = TV[v].run; bpr0_i = TV[v].b0; bpr1_i = TV[v].b1;
      used_cnt_i = TV[v].used; hp_grp_i = TV[v].grp; rd_idx_i = TV[v].idx;
      #1;
      chk("R9 hp query", hp_vid_o, TV[v].hp);
      chk("R9 query leaves entry", {rd_pend_o, rd_act_o}, 2'b10);
      do_ack(TV[v].grp);
      #1;
      chk("R8 done", ack_done_o, 1);
      chk("R5 R6 R7 R8 ok", ack_ok_o, TV[v].ok);
      chk("R5 R8 vid", ack_vid_o, TV[v].vid);
      if (TV[v].ok) chk("R7 R8 pre", ack_pre_o, TV[v].pre);
      chk("R8 R10 entry state", {rd_pend_o, rd_act_o}, TV[v].ok ? 2'b01 : 2'b10);
      @(negedge clk_i);
      chk("R10 done pulse", ack_done_o, 0);
    end

    // R4 tie order and idle priority, R8 other fields kept
    load_set();
    grp0_en_i = 0; grp1_en_i = 1; prio_mask_i = 8'hFF; run_prio_i = 8'hFF;
    bpr0_i = 0; bpr1_i = 0; used_cnt_i = 16;
    do_ack(1'b1); #1; chk("R4 first", ack_vid_o, 49);
    do_ack(1'b1); #1; chk("R4 tie lower index", ack_vid_o, 41);
    rd_idx_i = 1; #1;
    chk("R8 hw kept", rd_hw_o, 1);
    chk("R8 pid kept", rd_pid_o, 300);
    chk("R8 prio kept", rd_prio_o, 8'h40);
    chk("R8 grp kept", rd_grp_o, 1);
    do_ack(1'b1); #1; chk("R4 tie second", ack_vid_o, 44);
    do_ack(1'b1); #1; chk("R4 idle prio skipped", ack_vid_o, 1023);
    rd_idx_i = 6; #1;
    chk("R10 spurious leaves entry", {rd_pend_o, rd_act_o}, 2'b10);

    // R11 overwrite and readback
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 15; wr_vid_i = 10'd777; wr_prio_i = 8'h05;
    wr_grp_i = 0; wr_pend_i = 1; wr_act_i = 0; wr_hw_i = 1; wr_pid_i = 10'd512;
    @(negedge clk_i);
    wr_en_i = 0; rd_idx_i = 15; #1;
    chk("R11 vid", rd_vid_o, 777);
    chk("R11 pid", rd_pid_o, 512);
    chk("R11 prio", rd_prio_o, 5);
    grp0_en_i = 1; hp_grp_i = 0; #1;
    chk("R2 R9 new winner", hp_vid_o, 777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule